// File: doc/BRIEF.md
# Multi-Word Flash Program Sequencer

This block is the command front end that sits between a parallel bus-write port and the program controller of a NOR-style flash array. It decodes a setup code and counts the address/data write cycles that follow it. A single word program takes one such cycle, a double program takes two and a quadruple program takes four. Every collected address must fall in one aligned page, and no slot in that page may be written twice. When the last word arrives, the block launches the controller with a one-clock start pulse. The words are presented side by side in a packed vector, together with a slot mask and the page base address.

Once a launch has happened, bus reads return an 8-bit status byte instead of array data. The status shows ready/busy, a program-error flag and a low-programming-voltage flag. The error flags stay set until software sends an explicit clear. While the controller is working, the block ignores further writes except the suspend code. Suspend is forwarded as a one-clock request. A low level on the synchronous reset abandons any sequence or program in progress.

The write port follows valid/ready rules with `wr_ready` tied high, so the block never applies back-pressure. A cycle with `wr_valid` high is consumed at that clock edge. While busy, such a cycle is discarded unless it carries the suspend code. The launch port has no handshake: `start` is a single-cycle strobe, and `prog_addr`, `prog_mask` and `prog_data` are valid in that cycle.

Top module: `sfp_prog_seq`

## Requirements
- R1: In idle, the low byte of a write selects the operation. Code 0x40 is followed by one address/data cycle, 0x30 by two and 0x56 by four. `start` rises in the cycle after the clock edge that accepts the final address/data cycle, provided every cycle passed the page check.
- R2: `start` is high for exactly one clock per launch. In that cycle, `prog_addr` is the first address with bits [1:0] cleared. `prog_mask` bit i is set for the word whose address bits [1:0] equal i. `prog_data[i*DW +: DW]` holds that word's data.
- R3: For 0x30, address bits above bit 0 must match the first address. For 0x56, address bits above bit 1 must match. No slot may repeat. A failing cycle produces no launch, sets status bit 4, selects status reads and returns to idle.
- R4: The status byte, zero-extended on `rd_data`, has bit 7 = ready. Bit 7 is 0 from the launch until `ctl_done` and 1 otherwise. Bit 4 is the program error and bit 3 is the low-voltage flag. All other bits are 0.
- R5: After a launch, `rd_data` returns the status byte, including while busy, until a read-array code is accepted in idle.
- R6: In idle, code 0x70 selects status reads. Code 0xFF, or any code that is not listed, selects array reads, where `rd_data` equals `arr_rdata`.
- R7: Code 0x50 in idle clears status bits 4 and 3 and leaves the read selection unchanged. A new program launch does not clear them.
- R8: While busy, accepted writes have no effect on launches, status or read selection. The exception is code 0xB0, which raises `suspend_req` for one clock.
- R9: `rst_n` low at a clock edge aborts everything. `start` and `suspend_req` are low, any partial sequence is discarded, the status is 0x80 and reads return array data.
- R10: A launch proceeds with `hv_ok` low and sets status bit 3. With `hv_ok` high, bit 3 is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, aborts operation |
| wr_valid | input | 1 | Bus write cycle present |
| wr_ready | output | 1 | Always 1; writes are never stalled |
| wr_addr | input | AW | Bus write address |
| wr_data | input | DW | Bus write data (command code in bits [7:0]) |
| hv_ok | input | 1 | Programming voltage is within range |
| arr_rdata | input | DW | Array read data |
| rd_data | output | DW | Bus read data: array or status |
| start | output | 1 | One-clock program launch strobe |
| prog_addr | output | AW | Page base address of the launch |
| prog_data | output | 4*DW | Packed words, slot i in bits i*DW +: DW |
| prog_mask | output | 4 | Slots carrying a word |
| ctl_done | input | 1 | Program controller finished |
| suspend_req | output | 1 | One-clock suspend request while busy |

## Verification
The assertions take it for granted that `ctl_done` pulses only while a program is in progress, and that `wr_valid`, `hv_ok` and `rst_n` are never unknown after time zero. The stimulus drives every input to a defined value from the first instant. It changes inputs only at falling clock edges. It raises `ctl_done` only after it has seen a launch. The page-alignment property depends on the page check, so the stimulus also feeds deliberately misaligned and repeated addresses to show that these never reach `start`.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  localparam int PG_LG    = 2;
  localparam int PG_WORDS = 1 << PG_LG;
  localparam int LG_W     = $clog2(PG_LG + 1);
  localparam int CNT_W    = $clog2(PG_WORDS + 1);

  localparam logic [7:0] CODE_PROG1 = 8'h40;
  localparam logic [7:0] CODE_PROG2 = 8'h30;
  localparam logic [7:0] CODE_PROG4 = 8'h56;
  localparam logic [7:0] CODE_CLRST = 8'h50;
  localparam logic [7:0] CODE_RDST  = 8'h70;
  localparam logic [7:0] CODE_SUSP  = 8'hB0;

  localparam int SB_READY = 7;
  localparam int SB_PERR  = 4;
  localparam int SB_LOWV  = 3;

  typedef enum logic [2:0] {
    OP_PROG1, OP_PROG2, OP_PROG4, OP_CLRST, OP_RDST, OP_SUSP, OP_OTHER
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_COLLECT, ST_BUSY
  } seq_state_e;
endpackage

// File: rtl/sfp_cmd_decode.sv
module sfp_cmd_decode
  import sfp_pkg::*;
(
  input  logic [7:0]       code,
  output op_e              op,
  output logic [CNT_W-1:0] need,
  output logic [LG_W-1:0]  page_lg
);
  always_comb begin
    op      = OP_OTHER;
    need    = '0;
    page_lg = '0;
    case (code)
      CODE_PROG1: begin op = OP_PROG1; need = CNT_W'(1); page_lg = LG_W'(0); end
      CODE_PROG2: begin op = OP_PROG2; need = CNT_W'(2); page_lg = LG_W'(1); end
      CODE_PROG4: begin op = OP_PROG4; need = CNT_W'(PG_WORDS); page_lg = LG_W'(PG_LG); end
      CODE_CLRST: op = OP_CLRST;
      CODE_RDST:  op = OP_RDST;
      CODE_SUSP:  op = OP_SUSP;
      default:    op = OP_OTHER;
    endcase
  end
endmodule

// File: rtl/sfp_page_collector.sv
module sfp_page_collector
  import sfp_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   capture,
  input  logic [LG_W-1:0]        page_lg,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          data,
  output logic                   addr_ok,
  output logic [AW-1:0]          base_addr,
  output logic [PG_WORDS-1:0]    mask,
  output logic [PG_WORDS*DW-1:0] words
);
  logic [AW-1:0]       base_q;
  logic [PG_WORDS-1:0] mask_q;
  logic [PG_LG-1:0]    slot;
  logic [AW-1:0]       hi_sel;
  logic                first;
  logic                same_page;

  assign slot      = addr[PG_LG-1:0];
  assign hi_sel    = {AW{1'b1}} << page_lg;
  assign first     = (mask_q == '0);
  assign same_page = (((addr ^ base_q) & hi_sel) == '0);
  assign addr_ok   = first || (same_page && !mask_q[slot]);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) mask_q <= '0;
    else if (capture)    mask_q[slot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (capture && first) base_q <= addr;
  end

  for (genvar g = 0; g < PG_WORDS; g++) begin : g_word
    logic [DW-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                  word_q <= '0;
      else if (capture && slot == PG_LG'(g))       word_q <= data;
    end
    assign words[g*DW +: DW] = word_q;
  end

  assign mask      = mask_q;
  assign base_addr = {base_q[AW-1:PG_LG], {PG_LG{1'b0}}};
endmodule

// File: rtl/sfp_status_reg.sv
module sfp_status_reg
  import sfp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ready,
  input  logic       set_perr,
  input  logic       set_lowv,
  input  logic       clear_err,
  output logic [7:0] stat
);
  logic perr_q, lowv_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_err) begin
      perr_q <= 1'b0;
      lowv_q <= 1'b0;
    end else begin
      if (set_perr) perr_q <= 1'b1;
      if (set_lowv) lowv_q <= 1'b1;
    end
  end

  always_comb begin
    stat           = '0;
    stat[SB_READY] = ready;
    stat[SB_PERR]  = perr_q;
    stat[SB_LOWV]  = lowv_q;
  end
endmodule

// File: rtl/sfp_prog_seq.sv
module sfp_prog_seq
  import sfp_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic                   hv_ok,
  input  logic [DW-1:0]          arr_rdata,
  output logic [DW-1:0]          rd_data,
  output logic                   start,
  output logic [AW-1:0]          prog_addr,
  output logic [PG_WORDS*DW-1:0] prog_data,
  output logic [PG_WORDS-1:0]    prog_mask,
  input  logic                   ctl_done,
  output logic                   suspend_req
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] left_q;
  logic [LG_W-1:0]  pg_q;
  logic             smode_q;
  logic             start_q;
  logic             susp_q;

  op_e              op;
  logic [CNT_W-1:0] need;
  logic [LG_W-1:0]  page_lg;
  logic             addr_ok;
  logic             acc, is_prog, last_word;
  logic             col_clear, col_cap, set_perr, set_lowv, clr_err;
  logic             ready_w;
  logic [7:0]       stat_w;

  assign wr_ready = 1'b1;
  assign acc      = wr_valid;

  sfp_cmd_decode u_dec (
    .code    (wr_data[7:0]),
    .op      (op),
    .need    (need),
    .page_lg (page_lg)
  );

  assign is_prog   = (op == OP_PROG1) || (op == OP_PROG2) || (op == OP_PROG4);
  assign last_word = (left_q == CNT_W'(1));
  assign col_clear = (state_q == ST_IDLE) && acc && is_prog;
  assign col_cap   = (state_q == ST_COLLECT) && acc && addr_ok;
  assign set_perr  = (state_q == ST_COLLECT) && acc && !addr_ok;
  assign set_lowv  = col_cap && last_word && !hv_ok;
  assign clr_err   = (state_q == ST_IDLE) && acc && (op == OP_CLRST);
  assign ready_w   = (state_q != ST_BUSY);

  sfp_page_collector #(.AW(AW), .DW(DW)) u_col (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (col_clear),
    .capture   (col_cap),
    .page_lg   (pg_q),
    .addr      (wr_addr),
    .data      (wr_data),
    .addr_ok   (addr_ok),
    .base_addr (prog_addr),
    .mask      (prog_mask),
    .words     (prog_data)
  );

  sfp_status_reg u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (ready_w),
    .set_perr  (set_perr),
    .set_lowv  (set_lowv),
    .clear_err (clr_err),
    .stat      (stat_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      pg_q    <= '0;
      smode_q <= 1'b0;
      start_q <= 1'b0;
      susp_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      susp_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (acc) begin
            case (op)
              OP_PROG1, OP_PROG2, OP_PROG4: begin
                state_q <= ST_COLLECT;
                left_q  <= need;
                pg_q    <= page_lg;
              end
              OP_CLRST: smode_q <= smode_q;
              OP_RDST:  smode_q <= 1'b1;
              default:  smode_q <= 1'b0;
            endcase
          end
        end
        ST_COLLECT: begin
          if (acc) begin
            if (!addr_ok) begin
              state_q <= ST_IDLE;
              smode_q <= 1'b1;
            end else if (last_word) begin
              state_q <= ST_BUSY;
              start_q <= 1'b1;
              smode_q <= 1'b1;
            end else begin
              left_q <= left_q - CNT_W'(1);
            end
          end
        end
        ST_BUSY: begin
          if (acc && op == OP_SUSP) susp_q <= 1'b1;
          if (ctl_done) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign start       = start_q;
  assign suspend_req = susp_q;
  assign rd_data     = smode_q ? {{(DW-8){1'b0}}, stat_w} : arr_rdata;
endmodule

// File: rtl/sfp_checker.sv
module sfp_checker
  import sfp_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [PG_WORDS-1:0] prog_mask,
  input logic                hv_ok,
  input logic                ready,
  input logic                lowv,
  input logic                suspend_req
);
  assert_start_one_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

  assert_page_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (($countones(prog_mask) == 1) || (prog_mask == 4'b0011) ||
               (prog_mask == 4'b1100) || (prog_mask == 4'b1111)));

  assert_busy_after_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !ready);

  assert_no_launch_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> !start);

  assert_suspend_only_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    suspend_req |-> !$past(ready));

  assert_lowv_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !$past(hv_ok)) |-> lowv);

  assert_reset_abort_R9: assert property (@(posedge clk)
    !rst_n |=> (!start && !suspend_req && ready && !lowv));
endmodule

bind sfp_prog_seq sfp_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .prog_mask   (prog_mask),
  .hv_ok       (hv_ok),
  .ready       (ready_w),
  .lowv        (stat_w[3]),
  .suspend_req (suspend_req)
);

// File: tb/sim_sfp_prog_seq.sv
module sim_sfp_prog_seq;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam logic [15:0] ARR = 16'hC3E1;
  localparam logic [15:0] DX  = 16'h5A00;

  typedef struct packed {
    logic [7:0]  code;
    logic [2:0]  nwr;
    logic [15:0] a0, a1, a2, a3;
    logic        hv;
    logic [3:0]  mask;
    logic [15:0] paddr;
    logic [7:0]  sbusy;
    logic [7:0]  sfinal;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{8'h40, 3'd1, 16'h0123, 16'h0000, 16'h0000, 16'h0000, 1'b1, 4'b1000, 16'h0120, 8'h00, 8'h80},
    '{8'h30, 3'd2, 16'h0200, 16'h0201, 16'h0000, 16'h0000, 1'b1, 4'b0011, 16'h0200, 8'h00, 8'h80},
    '{8'h30, 3'd2, 16'h0203, 16'h0202, 16'h0000, 16'h0000, 1'b0, 4'b1100, 16'h0200, 8'h08, 8'h88},
    '{8'h30, 3'd2, 16'h0201, 16'h0203, 16'h0000, 16'h0000, 1'b1, 4'b0000, 16'h0000, 8'h90, 8'h90},
    '{8'h56, 3'd4, 16'h1002, 16'h1000, 16'h1003, 16'h1001, 1'b1, 4'b1111, 16'h1000, 8'h00, 8'h80},
    '{8'h56, 3'd4, 16'h1000, 16'h1001, 16'h1002, 16'h1005, 1'b1, 4'b0000, 16'h0000, 8'h90, 8'h90},
    '{8'h56, 3'd3, 16'h1000, 16'h1001, 16'h1001, 16'h0000, 1'b1, 4'b0000, 16'h0000, 8'h90, 8'h90},
    '{8'h30, 3'd2, 16'h0200, 16'h0200, 16'h0000, 16'h0000, 1'b1, 4'b0000, 16'h0000, 8'h90, 8'h90},
    '{8'h40, 3'd1, 16'h7FFE, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'b0100, 16'h7FFC, 8'h08, 8'h88}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          hv_ok = 1'b1;
  logic [DW-1:0] arr_rdata = ARR;
  logic [DW-1:0] rd_data;
  logic          start;
  logic [AW-1:0] prog_addr;
  logic [4*DW-1:0] prog_data;
  logic [3:0]    prog_mask;
  logic          ctl_done = 1'b0;
  logic          suspend_req;

  int checks = 0;
  int failures = 0;
  int nstart = 0;
  int nsusp = 0;
  logic [3:0]      cap_mask;
  logic [AW-1:0]   cap_addr;
  logic [4*DW-1:0] cap_data;

  always #4 clk = ~clk;

  sfp_prog_seq #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .hv_ok(hv_ok), .arr_rdata(arr_rdata),
    .rd_data(rd_data), .start(start), .prog_addr(prog_addr), .prog_data(prog_data),
    .prog_mask(prog_mask), .ctl_done(ctl_done), .suspend_req(suspend_req)
  );

  always @(negedge clk) begin
    if (start === 1'b1) begin
      nstart   = nstart + 1;
      cap_mask = prog_mask;
      cap_addr = prog_addr;
      cap_data = prog_data;
    end
    if (suspend_req === 1'b1) nsusp = nsusp + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    ctl_done = 1'b1;
    @(negedge clk);
    ctl_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic reset_pulse();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [15:0] pick(input vec_t v, input int k);
    case (k)
      0: return v.a0;
      1: return v.a1;
      2: return v.a2;
      default: return v.a3;
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state: array reads, no launch (R9, R6)
    check(start == 1'b0, "R9 start after reset", start, 0);
    check(rd_data == ARR, "R6 array read after reset", rd_data, ARR);
    check(wr_ready == 1'b1, "R1 wr_ready", wr_ready, 1);
    wr(16'h0, 16'h0070);
    check(rd_data == 16'h0080, "R4 idle status", rd_data, 16'h0080);
    wr(16'h0, 16'h00FF);

    // table walk (R1 R2 R3 R5 R7 R10)
    for (int i = 0; i < NV; i++) begin
      vec_t v = VEC[i];
      s0 = nstart;
      hv_ok = v.hv;
      wr(16'h0, {8'h00, v.code});
      for (int k = 0; k < int'(v.nwr); k++) wr(pick(v, k), pick(v, k) ^ DX);
      @(negedge clk);
      check(nstart - s0 == ((v.mask != 0) ? 1 : 0), $sformatf("R1 R3 launch count vec%0d", i),
            nstart - s0, (v.mask != 0) ? 1 : 0);
      if (v.mask != 0) begin
        check(cap_mask == v.mask, $sformatf("R2 mask vec%0d", i), cap_mask, v.mask);
        check(cap_addr == v.paddr, $sformatf("R2 base vec%0d", i), cap_addr, v.paddr);
        for (int k = 0; k < int'(v.nwr); k++) begin
          logic [15:0] a = pick(v, k);
          check(cap_data[a[1:0]*16 +: 16] == (a ^ DX), $sformatf("R2 word vec%0d slot%0d", i, a[1:0]),
                cap_data[a[1:0]*16 +: 16], a ^ DX);
        end
      end
      check(rd_data == {8'h00, v.sbusy}, $sformatf("R5 R10 status after launch vec%0d", i), rd_data, v.sbusy);
      if (v.mask != 0) begin
        done_pulse();
        check(rd_data == {8'h00, v.sfinal}, $sformatf("R4 status after done vec%0d", i), rd_data, v.sfinal);
      end
      hv_ok = 1'b1;
      wr(16'h0, 16'h0050);
      check(rd_data == 16'h0080, $sformatf("R7 clear status vec%0d", i), rd_data, 16'h0080);
      wr(16'h0, 16'h00FF);
      check(rd_data == ARR, $sformatf("R6 read array vec%0d", i), rd_data, ARR);
    end

    // writes while busy are ignored, suspend forwarded (R8)
    s0 = nstart;
    wr(16'h0, 16'h0040);
    wr(16'h0042, 16'h1111);
    wr(16'h0, 16'h0030);
    wr(16'h0300, 16'h2222);
    wr(16'h0301, 16'h3333);
    wr(16'h0, 16'h00FF);
    @(negedge clk);
    check(nstart - s0 == 1, "R8 no launch while busy", nstart - s0, 1);
    check(rd_data == 16'h0000, "R8 R5 status kept while busy", rd_data, 16'h0000);
    wr(16'h0, 16'h00B0);
    @(negedge clk);
    check(nsusp == 1, "R8 suspend pulse", nsusp, 1);
    done_pulse();
    check(rd_data == 16'h0080, "R4 ready after done", rd_data, 16'h0080);
    wr(16'h0, 16'h00FF);

    // error bit is sticky across a new launch (R7)
    wr(16'h0, 16'h0030);
    wr(16'h0010, 16'h0001);
    wr(16'h0012, 16'h0002);
    check(rd_data == 16'h0090, "R3 error status", rd_data, 16'h0090);
    wr(16'h0, 16'h0040);
    wr(16'h0055, 16'h0003);
    @(negedge clk);
    check(rd_data == 16'h0010, "R7 error kept on new launch", rd_data, 16'h0010);
    done_pulse();
    wr(16'h0, 16'h0050);
    check(rd_data == 16'h0080, "R7 cleared", rd_data, 16'h0080);

    // unknown code returns to array reads (R6)
    wr(16'h0, 16'h0012);
    check(rd_data == ARR, "R6 unknown code", rd_data, ARR);

    // reset during programming (R9)
    s0 = nstart;
    wr(16'h0, 16'h0056);
    for (int k = 0; k < 4; k++) wr(16'h2000 + 16'(k), 16'h4000 + 16'(k));
    @(negedge clk);
    check(nstart - s0 == 1, "R1 quad launch", nstart - s0, 1);
    reset_pulse();
    check(rd_data == ARR, "R9 array after abort", rd_data, ARR);
    check(start == 1'b0, "R9 start low after abort", start, 0);
    wr(16'h0, 16'h0070);
    check(rd_data == 16'h0080, "R9 status after abort", rd_data, 16'h0080);
    wr(16'h0, 16'h00FF);

    // reset in the middle of a sequence discards it (R9)
    s0 = nstart;
    wr(16'h0, 16'h0030);
    wr(16'h0400, 16'h5555);
    reset_pulse();
    check(nstart == s0, "R9 no launch after partial", nstart - s0, 0);
    wr(16'h0, 16'h0040);
    wr(16'h0401, 16'h6666);
    @(negedge clk);
    check(nstart - s0 == 1 && cap_mask == 4'b0010, "R9 R2 fresh single after reset", cap_mask, 4'b0010);
    check(cap_data[31:16] == 16'h6666, "R2 single word data", cap_data[31:16], 16'h6666);
    done_pulse();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule